// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block carries data words from one clock domain into a second clock domain that has no fixed phase or frequency relation to the first. The producer offers a word together with a push request on its own clock and watches a full flag. The consumer sees the oldest stored word on its data output whenever the empty flag is low, and pulses a pop request on its own clock to move on to the next word.

Each side owns a binary pointer that carries one bit more than the storage address. The extra bit is a wrap marker, so equal addresses can be told apart as empty or full. Only the Gray-coded form of a pointer leaves its domain. That form changes in a single bit per step, so a flop chain clocked by the receiving clock can sample it safely. Full is decided entirely on the write clock and empty entirely on the read clock. Both flags are registered and are computed from the pointer's next value, so a flag rises on the same edge as the operation that makes it true. A flag clears only after the other side's pointer has passed through the synchronizer.

Top module: `gray_fifo_dc`

## Requirements
- R1: While reset is held and right after it is released, `rd_empty` is 1 and `wr_full` is 0.
- R2: Every word accepted on the write side leaves on `rd_data` exactly once, in the order it was written, with nothing lost or added.
- R3: A push request while `wr_full` is 1 is ignored: the word is not stored and the write pointer does not move.
- R4: A pop request while `rd_empty` is 1 is ignored: the read pointer does not move, so the next word written is the next word read.
- R5: `wr_full` becomes 1 on the write-clock edge that stores the word occupying the last free location (2^ADDR_W words held), with no added latency.
- R6: `rd_empty` becomes 1 on the read-clock edge of the pop that removes the last stored word.
- R7: While `rd_empty` is 0, `rd_data` already shows the oldest stored word before any pop request is made.
- R8: After a push into an empty FIFO, `rd_empty` falls within 6 read-clock cycles. After a pop from a full FIFO, `wr_full` falls within 6 write-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_inc | input | 1 | Push request: store `wr_data` if not full |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Registered full flag, write domain |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_inc | input | 1 | Pop request: advance past the shown word if not empty |
| rd_data | output | DATA_W | Oldest stored word, valid while `rd_empty` is 0 |
| rd_empty | output | 1 | Registered empty flag, read domain |

## Verification
The bench targets the wrap boundary. It fills the FIFO to exactly 2^ADDR_W words and pushes once more. A wrong comparison of the wrap bit would either miss full and overwrite the oldest word, or raise full one word early. Both show up as a dropped or corrupted word, or a late flag, when the FIFO is drained. It also issues pops against an empty FIFO, where a design that let the pointer move would run ahead and then serve stale data. The flag latency tests catch a synchronizer chain that never delivers, or a flag computed from the current pointer instead of the next one, which would add a cycle of lag. A long run with random traffic on two unrelated clock periods crosses the pointers many times through every Gray transition, including the wrap.

// File: rtl/gray_fifo_dc_pkg.sv
package gray_fifo_dc_pkg;

  localparam int unsigned CODE_W = 32;

  // Reflected binary code of a counter value (upper bits zero-extended).
  function automatic logic [CODE_W-1:0] to_gray(input logic [CODE_W-1:0] bin);
    return bin ^ (bin >> 1);
  endfunction

endpackage

// File: rtl/gfd_sync.sv
module gfd_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  // First flop samples the foreign-domain value.
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gfd_storage.sv
module gfd_storage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: no reset, so the array maps onto RAM cells.
  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Asynchronous read port: head word is visible without a pop cycle.
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/gfd_wr_side.sv
module gfd_wr_side
  import gray_fifo_dc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic [ADDR_W:0]   rq_gray,
  output logic              full,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W:0]   ptr_gray
);

  localparam int unsigned PW = ADDR_W + 1;
  // Gray form of a half-range offset: the two top bits flipped.
  localparam logic [PW-1:0] WRAP_MASK = PW'(3) << (ADDR_W - 1);

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic          full_q, full_d;

  assign mem_we   = inc & ~full_q;
  assign bin_d    = bin_q + PW'(mem_we);
  assign gray_d   = PW'(to_gray(CODE_W'(bin_d)));
  assign full_d   = (gray_d == (rq_gray ^ WRAP_MASK));

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
      full_q <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      full_q <= full_d;
    end
  end

  assign full     = full_q;
  assign mem_addr = bin_q[ADDR_W-1:0];
  assign ptr_gray = gray_q;

  // R3: a push against a full FIFO leaves the pointer where it was.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && full_q) |=> $stable(bin_q));

  // R2: the crossing pointer moves by exactly one bit per stored word.
  p_wr_gray_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !full_q) |=> ($countones(gray_q ^ $past(gray_q)) == 1));

  // R1: full is low on the first cycle out of reset.
  p_wr_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !full_q);

endmodule

// File: rtl/gfd_rd_side.sv
module gfd_rd_side
  import gray_fifo_dc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic [ADDR_W:0]   wq_gray,
  output logic              empty,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W:0]   ptr_gray
);

  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic          empty_q, empty_d, pop;

  assign pop     = inc & ~empty_q;
  assign bin_d   = bin_q + PW'(pop);
  assign gray_d  = PW'(to_gray(CODE_W'(bin_d)));
  assign empty_d = (gray_d == wq_gray);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q   <= '0;
      gray_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      empty_q <= empty_d;
    end
  end

  assign empty    = empty_q;
  assign mem_addr = bin_q[ADDR_W-1:0];
  assign ptr_gray = gray_q;

  // R4: a pop against an empty FIFO leaves the pointer where it was.
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (inc && empty_q) |=> $stable(bin_q));

  // R2: read pointer crosses back one bit per step.
  p_rd_gray_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !empty_q) |=> ($countones(gray_q ^ $past(gray_q)) == 1));

  // R1: empty is high on the first cycle out of reset.
  p_rd_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> empty_q);

endmodule

// File: rtl/gray_fifo_dc.sv
module gray_fifo_dc #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_inc,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_inc,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0]     wr_gray, rd_gray, wr_gray_at_rd, rd_gray_at_wr;
  logic              mem_we;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  gfd_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk      (wr_clk),
    .rst      (wr_rst),
    .inc      (wr_inc),
    .rq_gray  (rd_gray_at_wr),
    .full     (wr_full),
    .mem_we   (mem_we),
    .mem_addr (wr_addr),
    .ptr_gray (wr_gray)
  );

  gfd_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk      (rd_clk),
    .rst      (rd_rst),
    .inc      (rd_inc),
    .wq_gray  (wr_gray_at_rd),
    .empty    (rd_empty),
    .mem_addr (rd_addr),
    .ptr_gray (rd_gray)
  );

  gfd_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk (rd_clk),
    .rst (rd_rst),
    .d   (wr_gray),
    .q   (wr_gray_at_rd)
  );

  gfd_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk (wr_clk),
    .rst (wr_rst),
    .d   (rd_gray),
    .q   (rd_gray_at_wr)
  );

  gfd_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk  (wr_clk),
    .wr_en   (mem_we),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/gray_fifo_dc_bench.sv
module gray_fifo_dc_bench;

  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DW        = 8;
  localparam int AW        = 4;
  localparam int DEPTH     = 1 << AW;
  localparam int RAND_N    = 600;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic          wr_inc = 1'b0, rd_inc = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, rd_empty;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  gray_fifo_dc #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_gray_fifo_dc (
    .wr_clk, .wr_rst, .wr_inc, .wr_data, .wr_full,
    .rd_clk, .rd_rst, .rd_inc, .rd_data, .rd_empty
  );

  logic [DW-1:0] model_q [$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One write-domain cycle: inputs change at the falling edge.
  task automatic wr_cycle(input bit en, input logic [DW-1:0] d, output bit acc);
    @(negedge wr_clk);
    wr_inc  = en;
    wr_data = d;
    acc     = en && !wr_full;
    if (acc) model_q.push_back(d);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_inc = 1'b0;
  endtask

  // One read-domain cycle: a pop is accepted at the next rising edge.
  task automatic rd_cycle(input bit en, output bit acc);
    @(negedge rd_clk);
    rd_inc = en;
    acc    = en && !rd_empty;
    if (acc) begin
      if (model_q.size() == 0) begin
        check(1'b0, "R2 read with model empty", 1, 0);
      end else begin
        check(rd_data == model_q[0], "R2 data order", int'(rd_data), int'(model_q[0]));
        void'(model_q.pop_front());
      end
    end
  endtask

  task automatic rd_idle();
    @(negedge rd_clk);
    rd_inc = 1'b0;
  endtask

  // Counts read cycles until empty falls (bounded).
  task automatic wait_not_empty(output int n);
    n = 0;
    while (rd_empty && n < 20) begin
      @(negedge rd_clk);
      n++;
    end
  endtask

  bit acc;
  int n;

  initial begin
    repeat (20000) @(posedge wr_clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge wr_clk);
    // R1: flags during reset
    check(rd_empty == 1'b1, "R1 empty in reset", int'(rd_empty), 1);
    check(wr_full == 1'b0, "R1 full in reset", int'(wr_full), 0);
    wr_rst = 1'b0;
    @(negedge rd_clk);
    rd_rst = 1'b0;
    repeat (3) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R1 empty after reset", int'(rd_empty), 1);
    check(wr_full == 1'b0, "R1 full after reset", int'(wr_full), 0);

    // R4: pops against an empty FIFO are ignored
    for (int i = 0; i < 4; i++) begin
      rd_cycle(1'b1, acc);
      check(!acc, "R4 pop accepted while empty", int'(acc), 0);
    end
    rd_idle();
    check(rd_empty == 1'b1, "R4 empty after ignored pops", int'(rd_empty), 1);

    // One word into an empty FIFO
    wr_cycle(1'b1, 8'h5A, acc);
    wr_idle();
    wait_not_empty(n);
    check(n <= 6, "R8 empty clear latency", n, 6);
    check(rd_data == 8'h5A, "R7 head word shown before pop", int'(rd_data), 8'h5A);
    check(rd_data == 8'h5A, "R4 pointer held after empty pops", int'(rd_data), 8'h5A);
    rd_cycle(1'b1, acc);
    rd_idle();
    check(rd_empty == 1'b1, "R6 empty on draining pop", int'(rd_empty), 1);

    // Fill to the brim with the reader idle
    repeat (6) @(negedge wr_clk);
    for (int i = 0; i < DEPTH; i++) begin
      wr_cycle(1'b1, 8'(8'h10 + i), acc);
      if (i == DEPTH - 1)
        check(wr_full == 1'b0, "R5 full not early", int'(wr_full), 0);
    end
    wr_idle();
    check(wr_full == 1'b1, "R5 full on filling edge", int'(wr_full), 1);

    // R3: extra push while full is dropped
    wr_cycle(1'b1, 8'hEE, acc);
    check(!acc, "R3 push accepted while full", int'(acc), 0);
    wr_idle();
    check(wr_full == 1'b1, "R3 still full after ignored push", int'(wr_full), 1);

    // One pop from a full FIFO, then time the full flag clearing
    wait_not_empty(n);
    check(rd_data == 8'h10, "R7 head word after fill", int'(rd_data), 8'h10);
    rd_cycle(1'b1, acc);
    rd_idle();
    n = 0;
    while (wr_full && n < 20) begin
      @(negedge wr_clk);
      n++;
    end
    check(n <= 6, "R8 full clear latency", n, 6);

    // Refill the freed slot, then drain everything
    wr_cycle(1'b1, 8'hC3, acc);
    wr_idle();
    check(wr_full == 1'b1, "R5 full after refill", int'(wr_full), 1);
    for (int i = 0; i < DEPTH; i++) rd_cycle(1'b1, acc);
    rd_idle();
    check(rd_empty == 1'b1, "R6 empty after drain", int'(rd_empty), 1);
    check(model_q.size() == 0, "R3 no extra word stored", model_q.size(), 0);

    // Random traffic on both clocks
    fork
      begin
        int sent = 0;
        while (sent < RAND_N) begin
          wr_cycle(($urandom % 4) != 0, 8'($urandom), acc);
          if (acc) sent++;
        end
        wr_idle();
      end
      begin
        bit racc;
        int got = 0;
        while (got < RAND_N) begin
          rd_cycle(($urandom % 3) != 0, racc);
          if (racc) got++;
        end
        rd_idle();
      end
    join
    repeat (8) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R2 empty after random run", int'(rd_empty), 1);
    check(model_q.size() == 0, "R2 all words delivered", model_q.size(), 0);
    check(wr_full == 1'b0, "R2 not full after random run", int'(wr_full), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule